// File: doc/BRIEF.md
# Rotating Interrupt Priority Resolver

This block arbitrates eight interrupt request lines for a processor. Each line is brought into the clock domain through a short synchronizer and captured into a request register, either on a rising transition or as a live level, one configuration bit per line. A mask register removes lines from arbitration. Among the unmasked pending lines, the block picks the one of highest priority and drives an interrupt line to the processor when that winner outranks everything currently in service.

The priority order is circular. A lowest-priority pointer names the level that ranks last. The level just after it ranks first. After reset the pointer is 7, so level 0 is highest and level 7 lowest. The processor acknowledges with a one-cycle pulse. The block answers with the granted level, moves the request into the in-service register, and later retires it with an end-of-interrupt command. That command is either non-specific (the highest in-service level) or specific (a named level), and either variant can also move the pointer. An acknowledge that finds nothing eligible reports level 7 as spurious.

Top module: `irq_prio_resolver`

## Requirements
- R1: With reset low at a rising edge (synchronous, active low), requests, in-service bits and mask clear, the pointer becomes 7, `int_out` is 0, `grant_level` is 7 and `grant_spurious` is 0.
- R2: With the pointer at 7, level 0 ranks highest and level 7 lowest, so with levels 3 and 6 pending every acknowledge grants level 3.
- R3: A line whose bit in the mask register is 1 (written with `mask_we`) is never granted and does not raise `int_out`.
- R4: For a line whose `irq_edge_cfg` bit is 1, the request is set only by a low-to-high transition of the synchronized input. It stays set after the input drops, until that level is acknowledged, and an input held high does not request again.
- R5: For a line whose `irq_edge_cfg` bit is 0, the request follows the synchronized input level, so a line that drops before acknowledge is no longer requested.
- R6: An acknowledge that meets `int_out` high sets the in-service bit of the winner, clears its request, and puts its number on `grant_level` with `grant_spurious` 0 one cycle later. A pending level does not raise `int_out` while a level of equal or higher priority is in service, but a higher level does (nesting).
- R7: An end-of-interrupt with `eoi_cmd` 2'b00 clears the highest-priority in-service bit under the current rotation and leaves the pointer unchanged.
- R8: `eoi_cmd` 2'b01 does the same and also sets the pointer to the level it cleared, so with levels 3 and 6 held pending the grants alternate 3, 6, 3.
- R9: `eoi_cmd` 2'b10 clears only the in-service bit numbered by `eoi_level` and leaves the pointer unchanged.
- R10: `eoi_cmd` 2'b11 clears the in-service bit numbered by `eoi_level` and sets the pointer to that level, so the following level becomes highest.
- R11: An acknowledge while `int_out` is low yields `grant_level` 7 and `grant_spurious` 1 one cycle later, in fixed and rotated order alike, and sets no in-service bit.
- R12: `int_out` is high exactly when some unmasked request is pending and the best of them ranks strictly above every in-service level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_in | input | 8 | Raw interrupt request lines |
| irq_edge_cfg | input | 8 | Per line: 1 = transition capture, 0 = level capture |
| mask_we | input | 1 | Load `mask_wdata` into the mask register |
| mask_wdata | input | 8 | New mask value, 1 disables a line |
| ack | input | 1 | One-cycle acknowledge from the processor |
| eoi_valid | input | 1 | Execute an end-of-interrupt command this cycle |
| eoi_cmd | input | 2 | 00 non-specific, 01 non-specific with rotate, 10 specific, 11 specific with rotate |
| eoi_level | input | 3 | Level named by specific commands |
| int_out | output | 1 | Interrupt request to the processor |
| grant_level | output | 3 | Level returned by the last acknowledge |
| grant_spurious | output | 1 | Last acknowledge found nothing eligible |

## Verification
The bench holds levels 3 and 6 pending and checks the order under fixed priority and under each rotate command. A resolver that rotates in the wrong direction, or does not rotate at all, returns 3 twice or 6 twice. It builds a nested in-service stack of 3 over 6 and retires the two levels out of order with a specific command. A design that blocks on the wrong side of the comparison, or clears the wrong bit, shows the wrong `int_out` at that point. It checks that a dropped transition-captured pulse survives until acknowledge while a dropped level does not. Spurious acknowledges are probed before and after rotation, and a later request for level 7 shows that a spurious grant left no in-service bit behind.

// File: rtl/irqp_pkg.sv
package irqp_pkg;

    // Number of request lines; must be a power of two so level arithmetic wraps.
    parameter int NUM_IRQ = 8;
    localparam int LVL_W = $clog2(NUM_IRQ);

    typedef logic [LVL_W-1:0]   lvl_t;
    typedef logic [NUM_IRQ-1:0] irq_vec_t;

    localparam lvl_t LVL_LAST = lvl_t'(NUM_IRQ - 1);

    typedef enum logic [1:0] {
        EOI_NONSPEC     = 2'b00,
        EOI_NONSPEC_ROT = 2'b01,
        EOI_SPEC        = 2'b10,
        EOI_SPEC_ROT    = 2'b11
    } eoi_cmd_e;

    typedef struct packed {
        logic hit;
        lvl_t level;
    } pick_t;

    // Rank 0 is the highest priority; the level after the pointer ranks first.
    function automatic lvl_t rank_of(lvl_t level, lvl_t lowest);
        return lvl_t'(level - lowest - lvl_t'(1));
    endfunction

    function automatic irq_vec_t onehot_of(lvl_t level);
        irq_vec_t v;
        v = '0;
        v[level] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/irqp_pick.sv
module irqp_pick
    import irqp_pkg::*;
(
    input  irq_vec_t req_i,
    input  lvl_t     lowest_i,
    output pick_t    pick_o
);
    // Scan from lowest rank to highest; the last hit is the best one.
    always_comb begin
        pick_o = '0;
        for (int k = NUM_IRQ - 1; k >= 0; k--) begin
            lvl_t cand;
            cand = lvl_t'(lowest_i + lvl_t'(k + 1));
            if (req_i[cand]) begin
                pick_o.hit   = 1'b1;
                pick_o.level = cand;
            end
        end
    end
endmodule

// File: rtl/irqp_capture.sv
module irqp_capture
    import irqp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  irq_vec_t irq_i,
    input  irq_vec_t edge_i,
    input  irq_vec_t clr_i,
    output irq_vec_t irr_o
);
    irq_vec_t sync_q [SYNC_STAGES];
    irq_vec_t prev_q;
    irq_vec_t irr_q;
    irq_vec_t rise;
    irq_vec_t irr_d;
    irq_vec_t line;

    assign line = sync_q[SYNC_STAGES-1];
    assign rise = line & ~prev_q;

    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sync_q[s] <= '0;
                end else if (s == 0) begin
                    sync_q[s] <= irq_i;
                end else begin
                    sync_q[s] <= sync_q[(s == 0) ? 0 : s - 1];
                end
            end
        end
    endgenerate

    always_comb begin
        irr_d = (edge_i & (irr_q | rise) & ~clr_i) | (~edge_i & line & ~clr_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            irr_q  <= '0;
        end else begin
            prev_q <= line;
            irr_q  <= irr_d;
        end
    end

    assign irr_o = irr_q;

    // R4
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(irr_q) & ~$past(clr_i) & $past(edge_i)) & ~irr_q) == '0));
endmodule

// File: rtl/irqp_service.sv
module irqp_service
    import irqp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  irq_vec_t pending_i,
    input  logic     ack_i,
    input  logic     eoi_valid_i,
    input  eoi_cmd_e eoi_cmd_i,
    input  lvl_t     eoi_level_i,
    output logic     int_o,
    output irq_vec_t clr_o,
    output lvl_t     grant_level_o,
    output logic     grant_spurious_o
);
    irq_vec_t isr_q;
    lvl_t     lowest_q;
    pick_t    req_pick;
    pick_t    isr_pick;
    irq_vec_t ack_set;
    irq_vec_t eoi_clr;
    lvl_t     lowest_d;
    logic     take;

    irqp_pick u_req_pick (.req_i(pending_i), .lowest_i(lowest_q), .pick_o(req_pick));
    irqp_pick u_isr_pick (.req_i(isr_q),     .lowest_i(lowest_q), .pick_o(isr_pick));

    always_comb begin
        int_o = req_pick.hit &&
                (!isr_pick.hit ||
                 (rank_of(req_pick.level, lowest_q) < rank_of(isr_pick.level, lowest_q)));
        take    = ack_i && int_o;
        ack_set = take ? onehot_of(req_pick.level) : '0;
        clr_o   = ack_set;
    end

    always_comb begin
        eoi_clr  = '0;
        lowest_d = lowest_q;
        if (eoi_valid_i) begin
            unique case (eoi_cmd_i)
                EOI_NONSPEC: begin
                    if (isr_pick.hit) eoi_clr = onehot_of(isr_pick.level);
                end
                EOI_NONSPEC_ROT: begin
                    if (isr_pick.hit) begin
                        eoi_clr  = onehot_of(isr_pick.level);
                        lowest_d = isr_pick.level;
                    end
                end
                EOI_SPEC: begin
                    eoi_clr = onehot_of(eoi_level_i);
                end
                EOI_SPEC_ROT: begin
                    eoi_clr  = onehot_of(eoi_level_i);
                    lowest_d = eoi_level_i;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_q            <= '0;
            lowest_q         <= LVL_LAST;
            grant_level_o    <= LVL_LAST;
            grant_spurious_o <= 1'b0;
        end else begin
            isr_q    <= (isr_q & ~eoi_clr) | ack_set;
            lowest_q <= lowest_d;
            if (ack_i) begin
                grant_level_o    <= take ? req_pick.level : LVL_LAST;
                grant_spurious_o <= !take;
            end
        end
    end

    // R6
    isr_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && int_o && !eoi_valid_i) |=> ($countones(isr_q) == $past($countones(isr_q)) + 1));

    // R11
    spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !int_o) |=> (grant_spurious_o && grant_level_o == LVL_LAST));

    // R10
    spec_rot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_valid_i && eoi_cmd_i == EOI_SPEC_ROT) |=> (lowest_q == $past(eoi_level_i)));
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
    import irqp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_IRQ-1:0]   irq_in,
    input  logic [NUM_IRQ-1:0]   irq_edge_cfg,
    input  logic                 mask_we,
    input  logic [NUM_IRQ-1:0]   mask_wdata,
    input  logic                 ack,
    input  logic                 eoi_valid,
    input  logic [1:0]           eoi_cmd,
    input  logic [LVL_W-1:0]     eoi_level,
    output logic                 int_out,
    output logic [LVL_W-1:0]     grant_level,
    output logic                 grant_spurious
);
    irq_vec_t mask_q;
    irq_vec_t irr;
    irq_vec_t clr;
    irq_vec_t pending;

    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= mask_wdata;
    end

    irqp_capture #(.SYNC_STAGES(SYNC_STAGES)) u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .irq_i  (irq_in),
        .edge_i (irq_edge_cfg),
        .clr_i  (clr),
        .irr_o  (irr)
    );

    assign pending = irr & ~mask_q;

    irqp_service u_service (
        .clk              (clk),
        .rst_n            (rst_n),
        .pending_i        (pending),
        .ack_i            (ack),
        .eoi_valid_i      (eoi_valid),
        .eoi_cmd_i        (eoi_cmd_e'(eoi_cmd)),
        .eoi_level_i      (eoi_level),
        .int_o            (int_out),
        .clr_o            (clr),
        .grant_level_o    (grant_level),
        .grant_spurious_o (grant_spurious)
    );

    // R12
    int_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> ((irr & ~mask_q) != '0));

    // R3
    masked_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && int_out) |=> !mask_q[grant_level]);
endmodule

// File: tb/irq_prio_resolver_tb.sv
module irq_prio_resolver_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_in = '0;
    logic [7:0] irq_edge_cfg = '0;
    logic       mask_we = 1'b0;
    logic [7:0] mask_wdata = '0;
    logic       ack = 1'b0;
    logic       eoi_valid = 1'b0;
    logic [1:0] eoi_cmd = '0;
    logic [2:0] eoi_level = '0;
    logic       int_out;
    logic [2:0] grant_level;
    logic       grant_spurious;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    irq_prio_resolver u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .irq_edge_cfg(irq_edge_cfg),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .ack(ack),
        .eoi_valid(eoi_valid), .eoi_cmd(eoi_cmd), .eoi_level(eoi_level),
        .int_out(int_out), .grant_level(grant_level), .grant_spurious(grant_spurious)
    );

    typedef struct packed {
        logic [7:0] irq;
        logic [7:0] mask;
        logic       exp_int;
        logic [2:0] exp_lvl;
        logic       exp_spur;
        logic       eoi_en;
        logic [1:0] eoi_cmd;
        logic [2:0] eoi_lvl;
    } step_t;

    localparam int NSTEP = 12;
    localparam step_t STEPS [NSTEP] = '{
        '{8'h48, 8'h00, 1'b1, 3'd3, 1'b0, 1'b1, 2'b00, 3'd0}, // R2 R7
        '{8'h48, 8'h00, 1'b1, 3'd3, 1'b0, 1'b1, 2'b01, 3'd0}, // R2 R8 -> ptr 3
        '{8'h48, 8'h00, 1'b1, 3'd6, 1'b0, 1'b1, 2'b01, 3'd0}, // R8 -> ptr 6
        '{8'h48, 8'h00, 1'b1, 3'd3, 1'b0, 1'b1, 2'b01, 3'd0}, // R8 -> ptr 3
        '{8'h00, 8'h00, 1'b0, 3'd7, 1'b1, 1'b0, 2'b00, 3'd0}, // R11 after rotate
        '{8'h48, 8'h08, 1'b1, 3'd6, 1'b0, 1'b1, 2'b10, 3'd6}, // R3 R9
        '{8'h48, 8'h48, 1'b0, 3'd7, 1'b1, 1'b0, 2'b00, 3'd0}, // R3 R11
        '{8'h48, 8'h00, 1'b1, 3'd6, 1'b0, 1'b1, 2'b11, 3'd6}, // R10 -> ptr 6
        '{8'h48, 8'h00, 1'b1, 3'd3, 1'b0, 1'b1, 2'b11, 3'd3}, // R10 -> ptr 3
        '{8'h81, 8'h00, 1'b1, 3'd7, 1'b0, 1'b1, 2'b10, 3'd7}, // R10 7 outranks 0
        '{8'h81, 8'h80, 1'b1, 3'd0, 1'b0, 1'b1, 2'b00, 3'd0}, // R3 R12
        '{8'h00, 8'h00, 1'b0, 3'd7, 1'b1, 1'b0, 2'b00, 3'd0}  // R11 R12
    };

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        irq_in = '0;
        cycles(3);
        rst_n = 1'b1;
        cycles(1);
    endtask

    task automatic write_mask(input logic [7:0] m);
        mask_wdata = m;
        mask_we = 1'b1;
        cycles(1);
        mask_we = 1'b0;
    endtask

    task automatic do_ack();
        ack = 1'b1;
        cycles(1);
        ack = 1'b0;
    endtask

    task automatic do_eoi(input logic [1:0] cmd, input logic [2:0] lvl);
        eoi_cmd = cmd;
        eoi_level = lvl;
        eoi_valid = 1'b1;
        cycles(1);
        eoi_valid = 1'b0;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset();
        check("R1 int_out", int_out, 0);
        check("R1 grant_level", grant_level, 7);
        check("R1 grant_spurious", grant_spurious, 0);

        // Table walk, level capture
        for (int i = 0; i < NSTEP; i++) begin
            write_mask(STEPS[i].mask);
            irq_in = STEPS[i].irq;
            cycles(5);
            check($sformatf("R12 step %0d int_out", i), int_out, STEPS[i].exp_int);
            do_ack();
            check($sformatf("R2 step %0d grant_level", i), grant_level, STEPS[i].exp_lvl);
            check($sformatf("R11 step %0d grant_spurious", i), grant_spurious, STEPS[i].exp_spur);
            if (STEPS[i].eoi_en) do_eoi(STEPS[i].eoi_cmd, STEPS[i].eoi_lvl);
        end

        // R6 nesting, R7 and R9 retiring out of order
        do_reset();
        irq_in = 8'h40;
        cycles(5);
        do_ack();
        check("R6 grant 6", grant_level, 6);
        cycles(1);
        check("R6 equal level blocked", int_out, 0);
        irq_in = 8'h48;
        cycles(5);
        check("R6 higher level nests", int_out, 1);
        do_ack();
        check("R6 grant 3", grant_level, 3);
        cycles(1);
        check("R6 both in service", int_out, 0);
        do_eoi(2'b00, 3'd0);
        check("R7 clears 3 not 6", int_out, 1);
        do_ack();
        check("R6 regrant 3", grant_level, 3);
        do_eoi(2'b10, 3'd6);
        check("R9 only 6 cleared", int_out, 0);
        do_eoi(2'b00, 3'd0);
        check("R7 3 cleared", int_out, 1);
        do_ack();
        check("R7 grant 3 again", grant_level, 3);

        // R4 transition capture
        do_reset();
        irq_edge_cfg = 8'hFF;
        irq_in = 8'h20;
        cycles(2);
        irq_in = 8'h00;
        cycles(5);
        check("R4 pulse held", int_out, 1);
        do_ack();
        check("R4 grant 5", grant_level, 5);
        do_eoi(2'b00, 3'd0);
        cycles(4);
        check("R4 cleared after ack", int_out, 0);
        irq_in = 8'h04;
        cycles(5);
        check("R4 rise on 2", int_out, 1);
        do_ack();
        check("R4 grant 2", grant_level, 2);
        do_eoi(2'b00, 3'd0);
        cycles(4);
        check("R4 held high no rerequest", int_out, 0);

        // R5 level capture
        irq_edge_cfg = 8'h00;
        cycles(4);
        check("R5 level requests", int_out, 1);
        do_ack();
        check("R5 grant 2", grant_level, 2);
        do_eoi(2'b00, 3'd0);
        cycles(4);
        check("R5 level rerequests", int_out, 1);
        irq_in = 8'h00;
        cycles(5);
        check("R5 dropped level gone", int_out, 0);
        do_ack();
        check("R5 spurious after drop", grant_spurious, 1);

        // R11 spurious leaves no in-service bit
        do_reset();
        do_ack();
        check("R11 level 7", grant_level, 7);
        check("R11 spurious flag", grant_spurious, 1);
        irq_in = 8'h80;
        cycles(5);
        check("R11 level 7 not blocked", int_out, 1);
        do_ack();
        check("R11 real grant 7", grant_level, 7);
        check("R11 real not spurious", grant_spurious, 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule